// File: doc/BRIEF.md
# Prescaler-Selectable Counter PWM

This block generates one pulse-width-modulated output from a single free-running counter. The counter advances on a slow reference enable, nominally 32 kHz. It does not compare against a period register. Instead, a two-bit frequency selector picks which counter bit, once set, sends the count back to zero. Each step of the selector halves the period and removes one bit of duty resolution. With an 8-bit counter this gives periods of 128, 64, 32 and 16 ticks: 250 Hz, 500 Hz, 1 kHz and 2 kHz.

Software reaches the block through a small synchronous byte bus. Address 0 holds the run flag and the frequency selector. Address 1 holds a 7-bit duty threshold. Both read back. Writes take effect on the next clock and do not wait for a period boundary. A change of frequency does not clear the counter. The output is high while the active low bits of the counter are below the duty threshold.

The threshold is only seven bits wide. At the slowest setting it therefore cannot reach the 128-tick period, and a full-high output is impossible there.

Top module: `pwm_prescaled_counter`

## Requirements
- R1: After reset, both registers read 0, the counter is 0 and `pwm_out` is low.
- R2: A write to address 0 stores bit 7 as the run flag and bits [1:0] as the frequency selector. A read of address 0 returns those bits in the same places, with bits [6:2] as 0.
- R3: A write to address 1 stores bits [6:0] as the duty threshold. A read of address 1 returns the threshold, with bit 7 as 0.
- R4: While running, the counter advances only in a clock cycle with `tick_en` high, and otherwise holds its value.
- R5: For selector value p, the counter returns to 0 on the tick that would set counter bit 7-p. The period is therefore 2^(7-p) ticks.
- R6: While running, `pwm_out` is high exactly when the counter bits below bit 7-p, read as a number, are less than the threshold. A threshold of 0 gives a constant low output.
- R7: A threshold of at least 2^(7-p) gives a constant high output. At p=0 the largest threshold, 127, gives 127 high ticks out of 128.
- R8: While the run flag is 0, `pwm_out` is low and the counter is held at 0. After the flag is set again, counting starts from 0.
- R9: Writing a new selector value does not change the counter value.
- R10: A new threshold acts on `pwm_out` in the cycle after the write, including in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Reference-rate enable, one cycle per count step |
| bus_addr | input | 1 | Register select: 0 control, 1 duty |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
A counter that is off by one, or that wraps on the wrong bit, shows at the pin. At the next rising edge the output stays high one tick too long or too short, or the pulse moves. Switching to the slowest setting with a threshold of 1 makes this visible within a single tick: the output is high only if the count really is 0.

A counter that is cleared when the selector changes cannot be seen in the width of the pulses. It is caught by setting a threshold one above the surviving masked count and one at that count. The output must differ between the two on the cycle after each write.

Register faults show up at the next read, or as a constant level on the output within one period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W      = 8;
  localparam int PSC_W      = 2;
  localparam int BUS_W      = 8;
  localparam int ADDR_W     = 1;
  localparam int RUN_BIT    = 7;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 1'b0;
  localparam logic [ADDR_W-1:0] DUTY_ADDR = 1'b1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int DUTY_W = CNT_W - 1,
  parameter int P_W    = PSC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              we,
  output logic [BUS_W-1:0]  rdata,
  output logic              run,
  output logic [P_W-1:0]    psc,
  output logic [DUTY_W-1:0] duty
);
  logic [BUS_W-1:0] ctrl_view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      psc  <= '0;
      duty <= '0;
    end else if (we) begin
      if (addr == CTRL_ADDR) begin
        run <= wdata[RUN_BIT];
        psc <= wdata[P_W-1:0];
      end else if (addr == DUTY_ADDR) begin
        duty <= wdata[DUTY_W-1:0];
      end
    end
  end

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[RUN_BIT] = run;
    ctrl_view[P_W-1:0] = psc;
    if (addr == CTRL_ADDR) rdata = ctrl_view;
    else                   rdata = BUS_W'(duty);
  end
endmodule

// File: rtl/pwm_cnt.sv
module pwm_cnt
  import pwm_pkg::*;
#(
  parameter int W   = CNT_W,
  parameter int P_W = PSC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [P_W-1:0] psc,
  output logic [W-1:0]  cnt,
  output logic [W-1:0]  mask
);
  localparam int NUM_SEL = 1 << P_W;

  logic [W-1:0]       cnt_inc;
  logic [NUM_SEL-1:0] wrap_vec;
  logic [W-1:0]       mask_vec [NUM_SEL];

  assign cnt_inc = cnt + W'(1);

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign wrap_vec[g] = cnt_inc[W-1-g];
    assign mask_vec[g] = {W{1'b1}} >> (g + 1);
  end

  assign mask = mask_vec[psc];

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= wrap_vec[psc] ? '0 : cnt_inc;
  end
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp
  import pwm_pkg::*;
#(
  parameter int W      = CNT_W,
  parameter int DUTY_W = CNT_W - 1
) (
  input  logic              run,
  input  logic [W-1:0]      cnt,
  input  logic [W-1:0]      mask,
  input  logic [DUTY_W-1:0] duty,
  output logic              out
);
  logic [W-1:0] active;

  assign active = cnt & mask;
  assign out    = run && (active[DUTY_W-1:0] < duty);
endmodule

// File: rtl/pwm_prescaled_counter.sv
module pwm_prescaled_counter
  import pwm_pkg::*;
#(
  parameter int W   = CNT_W,
  parameter int P_W = PSC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  localparam int DUTY_W = W - 1;

  logic              run_q;
  logic [P_W-1:0]    psc_q;
  logic [DUTY_W-1:0] duty_q;
  logic [W-1:0]      cnt_q;
  logic [W-1:0]      mask_w;

  pwm_regs #(.DUTY_W(DUTY_W), .P_W(P_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .we    (bus_we),
    .rdata (bus_rdata),
    .run   (run_q),
    .psc   (psc_q),
    .duty  (duty_q)
  );

  pwm_cnt #(.W(W), .P_W(P_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .tick  (tick_en),
    .psc   (psc_q),
    .cnt   (cnt_q),
    .mask  (mask_w)
  );

  pwm_cmp #(.W(W), .DUTY_W(DUTY_W)) u_cmp (
    .run  (run_q),
    .cnt  (cnt_q),
    .mask (mask_w),
    .duty (duty_q),
    .out  (pwm_out)
  );
endmodule

// File: rtl/pwm_chk.sv
module pwm_chk
  import pwm_pkg::*;
#(
  parameter int W   = CNT_W,
  parameter int P_W = PSC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_we,
  input logic              pwm_out,
  input logic              run_q,
  input logic [P_W-1:0]    psc_q,
  input logic [W-2:0]      duty_q,
  input logic [W-1:0]      cnt_q
);
  logic [W:0] span;
  assign span = (W+1)'(1) << (W - 1 - int'(psc_q));

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !pwm_out);

  assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_en) |=> $stable(cnt_q));

  assert_duty_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == DUTY_ADDR) |=> (duty_q == $past(bus_wdata[W-2:0])));

  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == CTRL_ADDR) |=>
      (run_q == $past(bus_wdata[RUN_BIT]) && psc_q == $past(bus_wdata[P_W-1:0])));

  assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_out);

  assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ({1'b0, 1'b0, duty_q} >= span)) |-> pwm_out);
endmodule

bind pwm_prescaled_counter pwm_chk #(.W(W), .P_W(P_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .pwm_out   (pwm_out),
  .run_q     (run_q),
  .psc_q     (psc_q),
  .duty_q    (duty_q),
  .cnt_q     (cnt_q)
);

// File: tb/tb_pwm_prescaled_counter.sv
module tb_pwm_prescaled_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [0:0] bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       pwm_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwm_prescaled_counter dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // {selector[1:0], threshold[6:0], expected high ticks per period[7:0]}
  localparam int NV = 10;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 7'd0,   8'd0},
    {2'd0, 7'd127, 8'd127},
    {2'd0, 7'd64,  8'd64},
    {2'd1, 7'd64,  8'd64},
    {2'd1, 7'd100, 8'd64},
    {2'd2, 7'd31,  8'd31},
    {2'd2, 7'd32,  8'd32},
    {2'd3, 7'd3,   8'd3},
    {2'd3, 7'd16,  8'd16},
    {2'd3, 7'd0,   8'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 out", pwm_out, 0);
    rd(1'b0, r); check("R1 ctrl read", r, 0);
    rd(1'b1, r); check("R1 duty read", r, 0);

    // R2 / R3 readback with unused bits
    wr(1'b0, 8'hFF); rd(1'b0, r); check("R2 ctrl readback", r, 8'h83);
    wr(1'b1, 8'hFF); rd(1'b1, r); check("R3 duty readback", r, 8'h7F);
    wr(1'b0, 8'h00);

    // Table: R6 / R7 pulse shape per selector and threshold
    for (int v = 0; v < NV; v++) begin
      int p; int d; int e; int n; int highs; int misplaced;
      p = int'(VEC[v][16:15]); d = int'(VEC[v][14:8]); e = int'(VEC[v][7:0]);
      n = 128 >> p;
      highs = 0; misplaced = 0;
      wr(1'b0, 8'h00);
      wr(1'b1, 8'(d));
      wr(1'b0, 8'h80 | 8'(p));
      for (int k = 0; k < n; k++) begin
        if (pwm_out) highs++;
        if (pwm_out != (k < d)) misplaced++;
        tick(1);
      end
      check($sformatf("R6/R7 highs p=%0d d=%0d", p, d), highs, e);
      check($sformatf("R6 placement p=%0d d=%0d", p, d), misplaced, 0);
    end

    // R4: no advance without tick_en
    wr(1'b0, 8'h00); wr(1'b1, 8'd1); wr(1'b0, 8'h83);
    repeat (10) @(negedge clk);
    check("R4 hold without tick", pwm_out, 1);
    tick(1);
    check("R4 advance on tick", pwm_out, 0);

    // R5: wrap on bit 4 at selector 3, observed through selector 0
    tick(14);
    check("R5 count 15 low", pwm_out, 0);
    tick(1);
    wr(1'b0, 8'h80);
    check("R5 wrapped to zero", pwm_out, 1);

    // R9: selector change keeps counter (count 20 -> masked 4 at selector 3)
    tick(20);
    wr(1'b1, 8'd21); check("R9 count20 thr21", pwm_out, 1);
    wr(1'b1, 8'd20); check("R9 count20 thr20", pwm_out, 0);
    wr(1'b0, 8'h83);
    wr(1'b1, 8'd5);  check("R9 sel3 thr5", pwm_out, 1);
    wr(1'b1, 8'd4);  check("R9 sel3 thr4", pwm_out, 0);
    wr(1'b0, 8'h80);
    wr(1'b1, 8'd21); check("R9 back sel0 thr21", pwm_out, 1);
    wr(1'b1, 8'd20); check("R9 back sel0 thr20", pwm_out, 0);

    // R10: mid-period threshold change
    wr(1'b0, 8'h00); wr(1'b1, 8'd10); wr(1'b0, 8'h82);
    tick(15);
    check("R10 before change", pwm_out, 0);
    wr(1'b1, 8'd20);
    check("R10 after change", pwm_out, 1);

    // R8: disable forces low and clears counter
    wr(1'b1, 8'd127); wr(1'b0, 8'h81);
    check("R8 enabled full", pwm_out, 1);
    wr(1'b0, 8'h01);
    check("R8 disabled low", pwm_out, 0);
    tick(5);
    check("R8 disabled ticks low", pwm_out, 0);
    wr(1'b1, 8'd1); wr(1'b0, 8'h83);
    check("R8 restart at zero", pwm_out, 1);

    summary();
    $finish;
  end
endmodule